// File: doc/BRIEF.md
# Byte-Code Fetch and Move Sequencer

This block is the control sequencer of a small 8-bit processor. It steps through instructions of one to three bytes held in a 256-byte RAM, reading the opcode and any operand bytes on consecutive cycles. It then carries out data moves between a four-entry register file (AL, BL, CL, DL) and RAM, or between AL and an 8-bit I/O port bus. Arithmetic, jump, stack and interrupt opcodes are not executed here. Their opcode and operand bytes are passed to an external unit on a one-cycle request.

The RAM and the port bus are outside the block, and both are read combinationally: the data answers the address in the same cycle. Each instruction passes through named states. `ST_FETCH` reads the opcode. `ST_OPND1` and `ST_OPND2` read the operand bytes. `ST_EXEC` performs a store, an immediate load, an output or a forward. `ST_WBACK` completes loads from RAM and port inputs. `ST_HALT` is terminal. The transitions are as follows:
- `ST_FETCH` goes to `ST_EXEC` for a 1-byte opcode and to `ST_OPND1` otherwise.
- `ST_OPND1` goes to `ST_OPND2` for a 3-byte opcode and to `ST_EXEC` otherwise.
- `ST_OPND2` goes to `ST_EXEC`.
- `ST_EXEC` goes to `ST_HALT` on the stop opcode or on an illegal instruction. It goes to `ST_WBACK` for a RAM load or a port input, and to `ST_FETCH` for everything else.
- `ST_WBACK` goes to `ST_FETCH`.
- `ST_HALT` stays in `ST_HALT` until reset.

The instruction pointer advances by the instruction length when the instruction finishes. Moves never touch any flag; flags belong to the external unit.

Top module: `mcu8_seq`

## Requirements
- R1: After reset the sequencer starts in `ST_FETCH` with the instruction pointer at 00, so the first `mem_addr` is 00. `halted` and `illegal_op` are low, and all four registers read 00.
- R2: Opcode D0 is laid out as opcode, register code, constant. It loads the constant into the register. Register codes are AL=00, BL=01, CL=02, DL=03.
- R3: Opcode D1 is laid out as opcode, register code, address. It loads the RAM byte at that address into the register.
- R4: Opcode D2 is laid out as opcode, address, register code. It writes the register to RAM at that address with `mem_we` high for one cycle.
- R5: Opcode D3 is laid out as opcode, destination register code, pointer register code. It loads the RAM byte addressed by the pointer register into the destination register.
- R6: Opcode D4 is laid out as opcode, pointer register code, source register code. It writes the source register to the RAM byte addressed by the pointer register.
- R7: Opcode F0 with a port byte asserts `io_rd` for one cycle with `io_addr` set to that port, and copies `io_rdata` into AL. Opcode F1 with a port byte asserts `io_wr` for one cycle with `io_addr` set to that port and `io_wdata` equal to AL.
- R8: Instruction lengths are as follows:
  - 1 byte: 00, FF, CB, CD, EA, EB, FC and FD.
  - 2 bytes: F0, F1, A4, A5, AD, 9A–9D, C0–C6, CA, CC, E0 and E1.
  - 3 bytes: D0–D4, A0–A3, A6, AA–AC, B0–B3, B6, BA–BC and DA–DC.

  The instruction pointer advances by the length modulo 256 and does not change while operand bytes are read. FF changes nothing else.
- R9: The non-move opcodes listed in R8 raise `alu_req` for one cycle in `ST_EXEC`. During that cycle `alu_opcode`, `alu_arg1` and `alu_arg2` carry the opcode and its operand bytes, with 00 for bytes the instruction lacks. Such opcodes change no register and no RAM byte.
- R10: Opcode 00 enters `ST_HALT` and raises `halted`, with the instruction pointer left at the address of that 00. From then on there are no writes, and `mem_addr` is stable until reset.
- R11: An opcode not listed in R8 raises `illegal_op` and halts, and so does a register code above 03 in a move. The offending instruction performs no write.
- R12: In any cycle, at most one of `mem_we`, `io_rd`, `io_wr` and `alu_req` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 8 | RAM address |
| mem_rdata | input | 8 | RAM read data for `mem_addr`, same cycle |
| mem_wdata | output | 8 | RAM write data |
| mem_we | output | 1 | RAM write enable |
| io_addr | output | 8 | Port number |
| io_rdata | input | 8 | Port read data, same cycle |
| io_wdata | output | 8 | Port write data |
| io_rd | output | 1 | Port read strobe |
| io_wr | output | 1 | Port write strobe |
| alu_req | output | 1 | One-cycle request carrying a forwarded opcode |
| alu_opcode | output | 8 | Forwarded opcode |
| alu_arg1 | output | 8 | First operand byte, or 00 |
| alu_arg2 | output | 8 | Second operand byte, or 00 |
| halted | output | 1 | Sequencer is in `ST_HALT` |
| illegal_op | output | 1 | Illegal instruction seen since reset |

## Verification
The bench targets byte order in the two store forms. A design that swapped the address and register bytes of D2, or the pointer and source bytes of D4, would write the wrong RAM cell or the wrong value. Instruction length is checked through the halt address after mixed 1-, 2- and 3-byte sequences. A wrong length would leave `mem_addr` elsewhere, or would execute an operand byte as an opcode. Register-clear on reset is checked by storing CL after a run that had loaded it. A bad register code must not reach the store, since a design that masked the code to two bits would silently write RAM. A halt must freeze the bus, so a design that kept fetching would eventually perform the store placed after it.

// File: rtl/mcu8_pkg.sv
package mcu8_pkg;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_OPND1,
        ST_OPND2,
        ST_EXEC,
        ST_WBACK,
        ST_HALT
    } seq_state_t;

    typedef enum logic [3:0] {
        K_STOP,   // 00
        K_IDLE,   // FF
        K_LDI,    // D0 reg,imm
        K_LDM,    // D1 reg,[addr]
        K_STM,    // D2 [addr],reg
        K_LDP,    // D3 reg,[reg]
        K_STP,    // D4 [reg],reg
        K_PIN,    // F0 port
        K_POUT,   // F1 port
        K_FWD,    // handed to the external unit
        K_BAD
    } op_kind_t;

endpackage

// File: rtl/mcu8_decode.sv
module mcu8_decode
    import mcu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] opcode,
    output op_kind_t      kind,
    output logic [1:0]    len
);

    always_comb begin
        kind = K_BAD;
        len  = 2'd1;
        case (opcode)
            8'h00: begin kind = K_STOP; len = 2'd1; end
            8'hFF: begin kind = K_IDLE; len = 2'd1; end
            8'hD0: begin kind = K_LDI;  len = 2'd3; end
            8'hD1: begin kind = K_LDM;  len = 2'd3; end
            8'hD2: begin kind = K_STM;  len = 2'd3; end
            8'hD3: begin kind = K_LDP;  len = 2'd3; end
            8'hD4: begin kind = K_STP;  len = 2'd3; end
            8'hF0: begin kind = K_PIN;  len = 2'd2; end
            8'hF1: begin kind = K_POUT; len = 2'd2; end
            8'hCB, 8'hCD, 8'hEA, 8'hEB, 8'hFC, 8'hFD:
                begin kind = K_FWD; len = 2'd1; end
            8'hA4, 8'hA5, 8'hAD, 8'h9A, 8'h9B, 8'h9C, 8'h9D,
            8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5, 8'hC6,
            8'hCA, 8'hCC, 8'hE0, 8'hE1:
                begin kind = K_FWD; len = 2'd2; end
            8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA6, 8'hAA, 8'hAB, 8'hAC,
            8'hB0, 8'hB1, 8'hB2, 8'hB3, 8'hB6, 8'hBA, 8'hBB, 8'hBC,
            8'hDA, 8'hDB, 8'hDC:
                begin kind = K_FWD; len = 2'd3; end
            default: begin kind = K_BAD; len = 2'd1; end
        endcase
    end

endmodule

// File: rtl/mcu8_regfile.sv
module mcu8_regfile #(
    parameter int DW   = 8,
    parameter int NREG = 4,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ra_a,
    input  logic [IW-1:0] ra_b,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    output logic [DW-1:0] acc
);

    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && waddr == IW'(g))
                regs[g] <= wdata;
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];
    assign acc  = regs[0];

endmodule

// File: rtl/mcu8_seq.sv
module mcu8_seq
    import mcu8_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [DW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic [DW-1:0] io_addr,
    input  logic [DW-1:0] io_rdata,
    output logic [DW-1:0] io_wdata,
    output logic          io_rd,
    output logic          io_wr,
    output logic          alu_req,
    output logic [DW-1:0] alu_opcode,
    output logic [DW-1:0] alu_arg1,
    output logic [DW-1:0] alu_arg2,
    output logic          halted,
    output logic          illegal_op
);

    localparam int IW = $clog2(NREG);
    localparam logic [DW-1:0] NREG_B = DW'(NREG);

    seq_state_t state, nstate;
    logic [DW-1:0] ip, opcode, b1, b2;
    logic          bad_q;

    op_kind_t      kind;
    logic [1:0]    len;
    logic [DW-1:0] dec_in;

    logic          wen;
    logic [IW-1:0] widx;
    logic [DW-1:0] wval, rd_a, rd_b, acc;
    logic          regs_ok, b1_ok, b2_ok, needs_wb;

    assign dec_in = (state == ST_FETCH) ? mem_rdata : opcode;

    mcu8_decode #(.DW(DW)) u_dec (
        .opcode (dec_in),
        .kind   (kind),
        .len    (len)
    );

    mcu8_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wen),
        .waddr (widx),
        .wdata (wval),
        .ra_a  (b1[IW-1:0]),
        .ra_b  (b2[IW-1:0]),
        .rd_a  (rd_a),
        .rd_b  (rd_b),
        .acc   (acc)
    );

    assign b1_ok = (b1 < NREG_B);
    assign b2_ok = (b2 < NREG_B);

    always_comb begin
        case (kind)
            K_LDI, K_LDM: regs_ok = b1_ok;
            K_STM:        regs_ok = b2_ok;
            K_LDP, K_STP: regs_ok = b1_ok && b2_ok;
            default:      regs_ok = 1'b1;
        endcase
    end

    assign needs_wb = (kind == K_LDM) || (kind == K_LDP) || (kind == K_PIN);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FETCH;
        else        state <= nstate;
    end

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            ST_FETCH: nstate = (len == 2'd1) ? ST_EXEC : ST_OPND1;
            ST_OPND1: nstate = (len == 2'd3) ? ST_OPND2 : ST_EXEC;
            ST_OPND2: nstate = ST_EXEC;
            ST_EXEC: begin
                if (kind == K_STOP || kind == K_BAD || !regs_ok)
                    nstate = ST_HALT;
                else if (needs_wb)
                    nstate = ST_WBACK;
                else
                    nstate = ST_FETCH;
            end
            ST_WBACK: nstate = ST_FETCH;
            ST_HALT:  nstate = ST_HALT;
        endcase
    end

    // outputs
    always_comb begin
        mem_addr   = ip;
        mem_wdata  = '0;
        mem_we     = 1'b0;
        io_addr    = '0;
        io_wdata   = '0;
        io_rd      = 1'b0;
        io_wr      = 1'b0;
        alu_req    = 1'b0;
        alu_opcode = opcode;
        alu_arg1   = b1;
        alu_arg2   = b2;
        wen        = 1'b0;
        widx       = b1[IW-1:0];
        wval       = b2;
        unique case (state)
            ST_FETCH: mem_addr = ip;
            ST_OPND1: mem_addr = ip + DW'(1);
            ST_OPND2: mem_addr = ip + DW'(2);
            ST_EXEC: begin
                if (regs_ok) begin
                    case (kind)
                        K_LDI: wen = 1'b1;
                        K_LDM: mem_addr = b2;
                        K_LDP: mem_addr = rd_b;
                        K_STM: begin
                            mem_addr  = b1;
                            mem_wdata = rd_b;
                            mem_we    = 1'b1;
                        end
                        K_STP: begin
                            mem_addr  = rd_a;
                            mem_wdata = rd_b;
                            mem_we    = 1'b1;
                        end
                        K_PIN: io_addr = b1;
                        K_POUT: begin
                            io_addr  = b1;
                            io_wdata = acc;
                            io_wr    = 1'b1;
                        end
                        K_FWD: alu_req = 1'b1;
                        default: ;
                    endcase
                end
            end
            ST_WBACK: begin
                wen  = 1'b1;
                wval = mem_rdata;
                if (kind == K_LDM) begin
                    mem_addr = b2;
                end else if (kind == K_LDP) begin
                    mem_addr = rd_b;
                end else begin
                    io_addr = b1;
                    io_rd   = 1'b1;
                    widx    = '0;
                    wval    = io_rdata;
                end
            end
            ST_HALT: mem_addr = ip;
        endcase
    end

    // instruction pointer and instruction bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip     <= '0;
            opcode <= '0;
            b1     <= '0;
            b2     <= '0;
            bad_q  <= 1'b0;
        end else begin
            case (state)
                ST_FETCH: begin
                    opcode <= mem_rdata;
                    b1     <= '0;
                    b2     <= '0;
                end
                ST_OPND1: b1 <= mem_rdata;
                ST_OPND2: b2 <= mem_rdata;
                ST_EXEC: begin
                    if (kind == K_BAD || !regs_ok)
                        bad_q <= 1'b1;
                    else if (kind != K_STOP && !needs_wb)
                        ip <= ip + DW'(len);
                end
                ST_WBACK: ip <= ip + DW'(len);
                default: ;
            endcase
        end
    end

    assign halted     = (state == ST_HALT);
    assign illegal_op = bad_q;

    // R12
    one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, io_rd, io_wr, alu_req}));

    // R10
    halt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && !mem_we && !io_wr && $stable(mem_addr));

    // R11
    illegal_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> halted);

    // R8
    ip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPND1 || state == ST_OPND2) |=> $stable(ip));

    // R7
    io_rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd |=> !io_rd);

    // R9
    alu_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_req |=> !alu_req);

endmodule

// File: tb/test_mcu8_seq.sv
`timescale 1ns/1ps
module test_mcu8_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mem_addr, mem_rdata, mem_wdata;
    logic       mem_we;
    logic [7:0] io_addr, io_rdata, io_wdata;
    logic       io_rd, io_wr, alu_req;
    logic [7:0] alu_opcode, alu_arg1, alu_arg2;
    logic       halted, illegal_op;

    logic [7:0] ram  [256];
    logic [7:0] pins [256];

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int we_cnt, wr_cnt, rd_cnt, alu_cnt;
    logic [7:0] last_port, last_out;
    logic [7:0] alu_log [8][3];

    always #5 clk = ~clk;

    assign mem_rdata = ram[mem_addr];
    assign io_rdata  = pins[io_addr];

    mcu8_seq i_mcu8_seq (
        .clk(clk), .rst_n(rst_n),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .io_addr(io_addr), .io_rdata(io_rdata), .io_wdata(io_wdata), .io_rd(io_rd), .io_wr(io_wr),
        .alu_req(alu_req), .alu_opcode(alu_opcode), .alu_arg1(alu_arg1), .alu_arg2(alu_arg2),
        .halted(halted), .illegal_op(illegal_op)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                ram[mem_addr] <= mem_wdata;
                we_cnt <= we_cnt + 1;
            end
            if (io_wr) begin
                wr_cnt    <= wr_cnt + 1;
                last_port <= io_addr;
                last_out  <= io_wdata;
            end
            if (io_rd) rd_cnt <= rd_cnt + 1;
            if (alu_req) begin
                if (alu_cnt < 8) begin
                    alu_log[alu_cnt][0] <= alu_opcode;
                    alu_log[alu_cnt][1] <= alu_arg1;
                    alu_log[alu_cnt][2] <= alu_arg2;
                end
                alu_cnt <= alu_cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_all();
        for (int i = 0; i < 256; i++) begin
            ram[i]  = 8'h00;
            pins[i] = 8'h00;
        end
    endtask

    task automatic start();
        rst_n = 1'b0;
        we_cnt = 0; wr_cnt = 0; rd_cnt = 0; alu_cnt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_to_halt(input string req);
        int n = 0;
        while (!halted && n < 500) begin
            @(negedge clk);
            n++;
        end
        chk(req, "reached halt", int'(halted), 1);
    endtask

    // R1 R2 R4: immediate load then direct store; reset state
    task automatic t_imm_store();
        clear_all();
        ram[0] = 8'hD0; ram[1] = 8'h01; ram[2] = 8'h5A;
        ram[3] = 8'hD2; ram[4] = 8'h40; ram[5] = 8'h01;
        ram[6] = 8'h00;
        start();
        chk("R1", "first fetch addr", int'(mem_addr), 0);
        chk("R1", "halted after reset", int'(halted), 0);
        chk("R1", "illegal after reset", int'(illegal_op), 0);
        run_to_halt("R2");
        chk("R4", "ram[40] from BL", int'(ram[8'h40]), 8'h5A);
        chk("R4", "single write", we_cnt, 1);
        chk("R8", "halt address", int'(mem_addr), 6);
        chk("R11", "no illegal", int'(illegal_op), 0);
    endtask

    // R3 R5 R6: direct load, pointer load, pointer store
    task automatic t_load_ptr();
        clear_all();
        ram[8'h80] = 8'hC3; ram[8'h81] = 8'h7E;
        ram[0]  = 8'hD1; ram[1]  = 8'h02; ram[2]  = 8'h80;   // CL = [80]
        ram[3]  = 8'hD0; ram[4]  = 8'h00; ram[5]  = 8'h90;   // AL = 90
        ram[6]  = 8'hD4; ram[7]  = 8'h00; ram[8]  = 8'h02;   // [AL] = CL
        ram[9]  = 8'hD0; ram[10] = 8'h03; ram[11] = 8'h81;   // DL = 81
        ram[12] = 8'hD3; ram[13] = 8'h01; ram[14] = 8'h03;   // BL = [DL]
        ram[15] = 8'hD2; ram[16] = 8'h91; ram[17] = 8'h01;   // [91] = BL
        ram[18] = 8'h00;
        start();
        run_to_halt("R3");
        chk("R6", "pointer store ram[90]", int'(ram[8'h90]), 8'hC3);
        chk("R5", "pointer load via ram[91]", int'(ram[8'h91]), 8'h7E);
        chk("R3", "source untouched ram[80]", int'(ram[8'h80]), 8'hC3);
        chk("R8", "halt address", int'(mem_addr), 18);
    endtask

    // R1: registers cleared by reset (CL was C3 from the previous run)
    task automatic t_reset_clears();
        clear_all();
        ram[8'h50] = 8'hFF;
        ram[0] = 8'hD2; ram[1] = 8'h50; ram[2] = 8'h02;
        ram[3] = 8'h00;
        start();
        run_to_halt("R1");
        chk("R1", "CL zero after reset", int'(ram[8'h50]), 0);
    endtask

    // R7: port input then output
    task automatic t_ports();
        clear_all();
        pins[8'h07] = 8'hA5;
        ram[0] = 8'hF0; ram[1] = 8'h07;
        ram[2] = 8'hF1; ram[3] = 8'h03;
        ram[4] = 8'h00;
        start();
        run_to_halt("R7");
        chk("R7", "read strobes", rd_cnt, 1);
        chk("R7", "write strobes", wr_cnt, 1);
        chk("R7", "out port", int'(last_port), 3);
        chk("R7", "out data", int'(last_out), 8'hA5);
        chk("R8", "halt address", int'(mem_addr), 4);
    endtask

    // R8 R9: NOPs and forwarded opcodes of every length
    task automatic t_forward();
        clear_all();
        ram[0] = 8'hFF; ram[1] = 8'hFF;
        ram[2] = 8'hD0; ram[3] = 8'h00; ram[4] = 8'h33;
        ram[5] = 8'hA0; ram[6] = 8'h00; ram[7] = 8'h01;
        ram[8] = 8'hA4; ram[9] = 8'h01;
        ram[10] = 8'hCB;
        ram[11] = 8'hD2; ram[12] = 8'h60; ram[13] = 8'h00;
        ram[14] = 8'h00;
        start();
        run_to_halt("R9");
        chk("R8", "halt address", int'(mem_addr), 14);
        chk("R9", "request count", alu_cnt, 3);
        chk("R9", "op0", int'(alu_log[0][0]), 8'hA0);
        chk("R9", "op0 arg2", int'(alu_log[0][2]), 8'h01);
        chk("R9", "op1", int'(alu_log[1][0]), 8'hA4);
        chk("R9", "op1 arg1", int'(alu_log[1][1]), 8'h01);
        chk("R9", "op1 arg2", int'(alu_log[1][2]), 0);
        chk("R9", "op2", int'(alu_log[2][0]), 8'hCB);
        chk("R9", "op2 arg1", int'(alu_log[2][1]), 0);
        chk("R9", "AL unchanged", int'(ram[8'h60]), 8'h33);
        chk("R8", "NOP no writes beyond store", we_cnt, 1);
    endtask

    // R11: bad register code and unknown opcode
    task automatic t_illegal();
        clear_all();
        ram[8'h40] = 8'hEE;
        ram[0] = 8'hD2; ram[1] = 8'h40; ram[2] = 8'h05;
        start();
        run_to_halt("R11");
        chk("R11", "illegal flag reg code", int'(illegal_op), 1);
        chk("R11", "no write", int'(ram[8'h40]), 8'hEE);
        chk("R11", "ip not advanced", int'(mem_addr), 0);
        clear_all();
        ram[0] = 8'hFF; ram[1] = 8'hD5; ram[2] = 8'hD2; ram[3] = 8'h40; ram[4] = 8'h00;
        start();
        run_to_halt("R11");
        chk("R11", "illegal flag opcode D5", int'(illegal_op), 1);
        chk("R11", "stopped at D5", int'(mem_addr), 1);
        chk("R11", "no writes", we_cnt, 0);
    endtask

    // R10: halt at address 0 freezes the machine
    task automatic t_halt_hold();
        clear_all();
        ram[8'h40] = 8'h11;
        ram[0] = 8'h00; ram[1] = 8'hD2; ram[2] = 8'h40; ram[3] = 8'h00;
        start();
        run_to_halt("R10");
        repeat (20) @(negedge clk);
        chk("R10", "still halted", int'(halted), 1);
        chk("R10", "addr held", int'(mem_addr), 0);
        chk("R10", "no writes", we_cnt, 0);
        chk("R10", "ram[40] untouched", int'(ram[8'h40]), 8'h11);
        chk("R10", "not illegal", int'(illegal_op), 0);
    endtask

    initial begin
        t_imm_store();
        t_load_ptr();
        t_reset_clears();
        t_ports();
        t_forward();
        t_illegal();
        t_halt_hold();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule